// File: doc/BRIEF.md
# Shared Word Memory with External Ownership Handshake

This block holds a 512-word by 16-bit memory shared between two masters. One side is a plain synchronous port used by logic inside the chip. It can read at any time, and it can write while it owns the memory. The other side is an asynchronous, SRAM-style port driven by an outside processor. Every control line on that side passes through a two-flop synchronizer before the block acts on it.

The outside processor takes the memory by raising a request line. The block answers with a grant a fixed number of clocks later, and withdraws the grant soon after the request falls. External reads and writes take effect only while the grant is high. While the grant is high, internal writes are refused and a flag reports each refused write.

An external write is open while chip select is low, read-not-write is low and at least one byte select is low. It commits when any of these three lines deasserts. The commit uses the address, data and byte lanes captured during the open phase. Read data leaves the external side with a separate enable flag, which stands in for a tri-state driver.

Top module: `coproc_shram`

## Requirements
- R1: After reset, `ext_gnt`, `ext_dout_en` and `int_wr_blocked` are all 0.
- R2: When `ext_req` rises, `ext_gnt` is 1 after exactly SYNC_STAGES + GRANT_DELAY rising clock edges. With the defaults, that is low after the third edge and high after the fourth.
- R3: When `ext_req` falls, `ext_gnt` is 0 after SYNC_STAGES + 1 rising clock edges and still 1 after SYNC_STAGES edges.
- R4: A granted external write is closed by chip select rising while both byte selects are low. It stores the full 16-bit word at `ext_addr`, and an internal read of that address returns the word.
- R5: Byte select bit 0 (active low) enables data bits [7:0], and byte select bit 1 enables bits [15:8]. An external write changes only the enabled lanes.
- R6: A granted external write also commits when read-not-write rises or when the byte selects all rise. The data and lanes are those held during the open phase.
- R7: `ext_dout_en` is 1 only while granted with chip select low, output enable low, read-not-write high and at least one byte select low. `ext_dout` then carries the word at `ext_addr`, with disabled lanes driven to 0.
- R8: An internal write attempted while `ext_gnt` is 1 leaves the memory unchanged, and `int_wr_blocked` is 1 in the following cycle.
- R9: While `ext_gnt` is 0, external writes change no memory word and `ext_dout_en` stays 0.
- R10: While `ext_gnt` is 0, an internal write stores a full word. An internal read returns data on `int_rdata` one clock after `int_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, clears the grant |
| int_en | input | 1 | Internal access strobe |
| int_we | input | 1 | Internal write when 1, read when 0 |
| int_addr | input | 9 | Internal word address |
| int_wdata | input | 16 | Internal write data |
| int_rdata | output | 16 | Internal read data, one clock after the strobe |
| int_wr_blocked | output | 1 | Pulses when an internal write is refused |
| ext_req | input | 1 | External ownership request |
| ext_gnt | output | 1 | Ownership granted to the external side |
| ext_addr | input | 9 | External word address |
| ext_cs_n | input | 1 | External chip select, active low |
| ext_oe_n | input | 1 | External output enable, active low |
| ext_rnw | input | 1 | External read (1) or write (0) |
| ext_bsel_n | input | 2 | Byte selects, active low; bit 1 upper lane, bit 0 lower lane |
| ext_din | input | 16 | External write data |
| ext_dout | output | 16 | External read data |
| ext_dout_en | output | 1 | Read data drive enable |

## Verification
The bench uses the default parameters: a 9-bit address, 16-bit data, two synchronizer stages and a grant delay of two. With these values the bench can reach the first and last words, both byte lanes on their own and together, and the exact edge on which the grant rises and falls. Each of the three write-termination strobes is exercised on its own, and every result is read back through the internal port.

// File: rtl/coproc_shram_pkg.sv
package coproc_shram_pkg;
   localparam int LANE_W = 8;

   function automatic int lanes_of(input int data_w);
      return data_w / LANE_W;
   endfunction
endpackage

// File: rtl/coproc_shram_sync.sv
module coproc_shram_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= RST_VAL;
      else        chain_q[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= RST_VAL;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/coproc_shram_arb.sv
module coproc_shram_arb #(
   parameter int GRANT_DELAY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_s,
   output logic gnt_o
);
   localparam int CW = $clog2(GRANT_DELAY + 1);

   logic [CW-1:0] wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q <= '0;
         gnt_o  <= 1'b0;
      end else if (!req_s) begin
         wait_q <= '0;
         gnt_o  <= 1'b0;
      end else if (!gnt_o) begin
         if (wait_q == CW'(GRANT_DELAY - 1)) gnt_o  <= 1'b1;
         else                                wait_q <= wait_q + CW'(1);
      end
   end

   // grant only rises on a request held across the previous edge
   p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt_o) |-> (req_s && $past(req_s)));

   // a withdrawn request removes the grant on the next edge
   p_grant_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_s |=> !gnt_o);
endmodule

// File: rtl/coproc_shram_ext.sv
module coproc_shram_ext #(
   parameter int AW    = 9,
   parameter int DW    = 16,
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gnt_i,
   input  logic             cs_n_s,
   input  logic             oe_n_s,
   input  logic             rnw_s,
   input  logic [LANES-1:0] bsel_n_s,
   input  logic [AW-1:0]    addr_i,
   input  logic [DW-1:0]    din_i,
   output logic             wr_en_o,
   output logic [AW-1:0]    wr_addr_o,
   output logic [DW-1:0]    wr_data_o,
   output logic [LANES-1:0] wr_be_o,
   output logic             rd_en_o,
   output logic [LANES-1:0] rd_be_o
);
   logic wr_open, wr_open_q;

   assign wr_open = !cs_n_s && !rnw_s && (|(~bsel_n_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_open_q <= 1'b0;
      else        wr_open_q <= wr_open;
   end

   always_ff @(posedge clk) begin
      if (wr_open) begin
         wr_addr_o <= addr_i;
         wr_data_o <= din_i;
         wr_be_o   <= ~bsel_n_s;
      end
   end

   assign wr_en_o = wr_open_q && !wr_open && gnt_i;
   assign rd_en_o = gnt_i && !cs_n_s && !oe_n_s && rnw_s && (|(~bsel_n_s));
   assign rd_be_o = ~bsel_n_s;

   // a commit only follows a cycle with the write open
   p_commit_after_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> $past(wr_open));
endmodule

// File: rtl/coproc_shram_mem.sv
module coproc_shram_mem #(
   parameter int AW    = 9,
   parameter int LANES = 2
) (
   input  logic                 clk,
   input  logic                 we_i,
   input  logic [AW-1:0]        waddr_i,
   input  logic [LANES*8-1:0]   wdata_i,
   input  logic [LANES-1:0]     be_i,
   input  logic                 ra_en_i,
   input  logic [AW-1:0]        ra_addr_i,
   output logic [LANES*8-1:0]   ra_q_o,
   input  logic [AW-1:0]        rb_addr_i,
   output logic [LANES*8-1:0]   rb_q_o
);
   localparam int DEPTH = 1 << AW;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (we_i && be_i[l]) store[waddr_i] <= wdata_i[l*8 +: 8];
         if (ra_en_i)         ra_q_o[l*8 +: 8] <= store[ra_addr_i];
         rb_q_o[l*8 +: 8] <= store[rb_addr_i];
      end
   end
endmodule

// File: rtl/coproc_shram.sv
module coproc_shram
   import coproc_shram_pkg::*;
#(
   parameter int ADDR_W      = 9,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int GRANT_DELAY = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          int_en,
   input  logic                          int_we,
   input  logic [ADDR_W-1:0]             int_addr,
   input  logic [DATA_W-1:0]             int_wdata,
   output logic [DATA_W-1:0]             int_rdata,
   output logic                          int_wr_blocked,
   input  logic                          ext_req,
   output logic                          ext_gnt,
   input  logic [ADDR_W-1:0]             ext_addr,
   input  logic                          ext_cs_n,
   input  logic                          ext_oe_n,
   input  logic                          ext_rnw,
   input  logic [DATA_W/LANE_W-1:0]      ext_bsel_n,
   input  logic [DATA_W-1:0]             ext_din,
   output logic [DATA_W-1:0]             ext_dout,
   output logic                          ext_dout_en
);
   localparam int LANES  = lanes_of(DATA_W);
   localparam int CTRL_W = LANES + 4;
   localparam logic [CTRL_W-1:0] CTRL_IDLE = {1'b0, 3'b111, {LANES{1'b1}}};

   if (DATA_W % LANE_W != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of byte lanes");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (GRANT_DELAY < 1) begin : g_bad_delay
      $error("GRANT_DELAY must be at least 1");
   end

   logic [CTRL_W-1:0] ctrl_s;
   logic              req_s, cs_n_s, oe_n_s, rnw_s;
   logic [LANES-1:0]  bsel_n_s;

   coproc_shram_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({ext_req, ext_cs_n, ext_oe_n, ext_rnw, ext_bsel_n}),
      .q_o   (ctrl_s)
   );

   assign {req_s, cs_n_s, oe_n_s, rnw_s, bsel_n_s} = ctrl_s;

   coproc_shram_arb #(.GRANT_DELAY(GRANT_DELAY)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req_s (req_s),
      .gnt_o (ext_gnt)
   );

   logic              ext_wr_en;
   logic [ADDR_W-1:0] ext_wr_addr;
   logic [DATA_W-1:0] ext_wr_data;
   logic [LANES-1:0]  ext_wr_be;
   logic [LANES-1:0]  ext_rd_be;

   coproc_shram_ext #(.AW(ADDR_W), .DW(DATA_W), .LANES(LANES)) u_ext (
      .clk       (clk),
      .rst_n     (rst_n),
      .gnt_i     (ext_gnt),
      .cs_n_s    (cs_n_s),
      .oe_n_s    (oe_n_s),
      .rnw_s     (rnw_s),
      .bsel_n_s  (bsel_n_s),
      .addr_i    (ext_addr),
      .din_i     (ext_din),
      .wr_en_o   (ext_wr_en),
      .wr_addr_o (ext_wr_addr),
      .wr_data_o (ext_wr_data),
      .wr_be_o   (ext_wr_be),
      .rd_en_o   (ext_dout_en),
      .rd_be_o   (ext_rd_be)
   );

   logic int_wr_ok;
   assign int_wr_ok = int_en && int_we && !ext_gnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) int_wr_blocked <= 1'b0;
      else        int_wr_blocked <= int_en && int_we && ext_gnt;
   end

   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [DATA_W-1:0] mem_wdata;
   logic [LANES-1:0]  mem_be;
   logic [DATA_W-1:0] ext_q;

   assign mem_we    = ext_wr_en || int_wr_ok;
   assign mem_waddr = ext_wr_en ? ext_wr_addr : int_addr;
   assign mem_wdata = ext_wr_en ? ext_wr_data : int_wdata;
   assign mem_be    = ext_wr_en ? ext_wr_be   : {LANES{1'b1}};

   coproc_shram_mem #(.AW(ADDR_W), .LANES(LANES)) u_mem (
      .clk       (clk),
      .we_i      (mem_we),
      .waddr_i   (mem_waddr),
      .wdata_i   (mem_wdata),
      .be_i      (mem_be),
      .ra_en_i   (int_en && !int_we),
      .ra_addr_i (int_addr),
      .ra_q_o    (int_rdata),
      .rb_addr_i (ext_addr),
      .rb_q_o    (ext_q)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_dout
      assign ext_dout[l*LANE_W +: LANE_W] = ext_rd_be[l] ? ext_q[l*LANE_W +: LANE_W] : '0;
   end

   // read drive only while the external side owns the memory
   p_dout_needs_gnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ext_dout_en |-> ext_gnt);

   // a write attempted under grant is reported on the next edge
   p_block_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (int_en && int_we && ext_gnt) |=> int_wr_blocked);

   // never two writers on the same edge
   p_one_writer_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_wr_en && int_wr_ok));

   // external commits only under grant
   p_ext_wr_gnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ext_wr_en |-> ext_gnt);
endmodule

// File: tb/coproc_shram_tb_top.sv
`timescale 1ns/1ps
module coproc_shram_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        int_en = 1'b0, int_we = 1'b0;
   logic [8:0]  int_addr = '0;
   logic [15:0] int_wdata = '0;
   logic [15:0] int_rdata;
   logic        int_wr_blocked;
   logic        ext_req = 1'b0;
   logic        ext_gnt;
   logic [8:0]  ext_addr = '0;
   logic        ext_cs_n = 1'b1, ext_oe_n = 1'b1, ext_rnw = 1'b1;
   logic [1:0]  ext_bsel_n = 2'b11;
   logic [15:0] ext_din = '0;
   logic [15:0] ext_dout;
   logic        ext_dout_en;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   coproc_shram dut_i (
      .clk(clk), .rst_n(rst_n),
      .int_en(int_en), .int_we(int_we), .int_addr(int_addr),
      .int_wdata(int_wdata), .int_rdata(int_rdata), .int_wr_blocked(int_wr_blocked),
      .ext_req(ext_req), .ext_gnt(ext_gnt), .ext_addr(ext_addr),
      .ext_cs_n(ext_cs_n), .ext_oe_n(ext_oe_n), .ext_rnw(ext_rnw),
      .ext_bsel_n(ext_bsel_n), .ext_din(ext_din),
      .ext_dout(ext_dout), .ext_dout_en(ext_dout_en)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic ext_idle();
      ext_cs_n = 1'b1; ext_oe_n = 1'b1; ext_rnw = 1'b1; ext_bsel_n = 2'b11;
   endtask

   task automatic int_write(input logic [8:0] a, input logic [15:0] d);
      int_en = 1'b1; int_we = 1'b1; int_addr = a; int_wdata = d;
      @(posedge clk); @(negedge clk);
      int_en = 1'b0; int_we = 1'b0;
   endtask

   task automatic int_read(input logic [8:0] a, output logic [15:0] d);
      int_en = 1'b1; int_we = 1'b0; int_addr = a;
      @(posedge clk); @(negedge clk);
      int_en = 1'b0;
      d = int_rdata;
   endtask

   // term: 0 chip select rises, 1 read-not-write rises, 2 byte selects rise
   task automatic ext_write(input logic [8:0] a, input logic [15:0] d,
                            input logic [1:0] bs_n, input int term);
      ext_addr = a; ext_din = d; ext_oe_n = 1'b1;
      ext_rnw = 1'b0; ext_bsel_n = bs_n; ext_cs_n = 1'b0;
      edges(4);
      if (term == 0)      ext_cs_n = 1'b1;
      else if (term == 1) ext_rnw = 1'b1;
      else                ext_bsel_n = 2'b11;
      edges(5);
      ext_idle();
      edges(1);
   endtask

   task automatic ext_read(input logic [8:0] a, input logic [1:0] bs_n, input logic oe_n,
                           output logic en, output logic [15:0] d);
      ext_addr = a; ext_rnw = 1'b1; ext_bsel_n = bs_n; ext_oe_n = oe_n; ext_cs_n = 1'b0;
      edges(4);
      en = ext_dout_en; d = ext_dout;
      ext_idle();
      edges(3);
   endtask

   task automatic t_reset();
      check("R1 gnt", {15'd0, ext_gnt}, 16'd0);
      check("R1 dout_en", {15'd0, ext_dout_en}, 16'd0);
      check("R1 blocked", {15'd0, int_wr_blocked}, 16'd0);
   endtask

   task automatic t_internal();
      logic [15:0] v;
      int_write(9'd5, 16'h1234);
      int_write(9'd511, 16'hBEEF);
      int_write(9'd0, 16'h0000);
      int_read(9'd5, v);   check("R10 read addr 5", v, 16'h1234);
      int_read(9'd511, v); check("R10 read addr 511", v, 16'hBEEF);
      int_read(9'd0, v);   check("R10 read addr 0", v, 16'h0000);
   endtask

   task automatic t_no_grant();
      logic [15:0] v; logic en;
      ext_write(9'd5, 16'hDEAD, 2'b00, 0);
      int_read(9'd5, v); check("R9 ungranted write ignored", v, 16'h1234);
      ext_read(9'd5, 2'b00, 1'b0, en, v);
      check("R9 ungranted read not driven", {15'd0, en}, 16'd0);
   endtask

   task automatic t_grant_rise();
      ext_req = 1'b1;
      edges(3); check("R2 gnt low after 3 edges", {15'd0, ext_gnt}, 16'd0);
      edges(1); check("R2 gnt high after 4 edges", {15'd0, ext_gnt}, 16'd1);
   endtask

   task automatic t_ext_writes();
      logic [15:0] v;
      ext_write(9'd7, 16'hA5C3, 2'b00, 0);
      int_read(9'd7, v); check("R4 full write cs end", v, 16'hA5C3);
      ext_write(9'd5, 16'h7788, 2'b10, 0);
      int_read(9'd5, v); check("R5 lower lane only", v, 16'h1288);
      ext_write(9'd511, 16'h1122, 2'b01, 1);
      int_read(9'd511, v); check("R5 R6 upper lane, rnw end", v, 16'h11EF);
      ext_write(9'd7, 16'h0F0F, 2'b00, 2);
      int_read(9'd7, v); check("R6 byte select end", v, 16'h0F0F);
      ext_write(9'd0, 16'h8001, 2'b00, 1);
      int_read(9'd0, v); check("R6 rnw end addr 0", v, 16'h8001);
   endtask

   task automatic t_ext_reads();
      logic [15:0] v; logic en;
      ext_read(9'd7, 2'b00, 1'b0, en, v);
      check("R7 read enable", {15'd0, en}, 16'd1);
      check("R7 read data both lanes", v, 16'h0F0F);
      ext_read(9'd511, 2'b10, 1'b0, en, v);
      check("R7 lower lane data", v, 16'h00EF);
      ext_read(9'd511, 2'b01, 1'b0, en, v);
      check("R7 upper lane data", v, 16'h1100);
      ext_read(9'd7, 2'b00, 1'b1, en, v);
      check("R7 oe high not driven", {15'd0, en}, 16'd0);
      ext_read(9'd7, 2'b11, 1'b0, en, v);
      check("R7 no lane not driven", {15'd0, en}, 16'd0);
   endtask

   task automatic t_blocked();
      logic [15:0] v;
      int_write(9'd7, 16'hFFFF);
      check("R8 blocked flag", {15'd0, int_wr_blocked}, 16'd1);
      edges(1);
      check("R8 flag clears", {15'd0, int_wr_blocked}, 16'd0);
      int_read(9'd7, v); check("R8 memory unchanged", v, 16'h0F0F);
   endtask

   task automatic t_grant_drop();
      logic [15:0] v; logic en;
      ext_req = 1'b0;
      edges(2); check("R3 gnt still high after 2 edges", {15'd0, ext_gnt}, 16'd1);
      edges(1); check("R3 gnt low after 3 edges", {15'd0, ext_gnt}, 16'd0);
      ext_read(9'd7, 2'b00, 1'b0, en, v);
      check("R9 read after release not driven", {15'd0, en}, 16'd0);
      int_write(9'd7, 16'h3C3C);
      int_read(9'd7, v); check("R10 internal write after release", v, 16'h3C3C);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      edges(3);
      rst_n = 1'b1;
      edges(1);
      t_reset();
      t_internal();
      t_no_grant();
      t_grant_rise();
      t_ext_writes();
      t_ext_reads();
      t_blocked();
      t_grant_drop();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule